// File: doc/BRIEF.md
# Channelised Link Timeslot Demultiplexer

This block sits behind a framed T1/J1 or E1 receive link. It takes the serial
line one bit at a time, with a strobe for each bit and a pulse that marks the
first bit of a frame. It tracks where each bit sits inside the frame. A
per-timeslot table, written through a simple write port, says which HDLC
channel owns each timeslot, or that the timeslot belongs to no channel. For
every bit that belongs to a channel, the block hands the bit, its channel
number and a valid strobe to the HDLC receive logic downstream. A marker
flags the first bit of each timeslot octet, so that a transparent-mode
consumer can keep its octets lined up with timeslots.

Two options shape what is delivered. A per-channel 56 kbit/s setting drops
the last bit of every timeslot owned by that channel. A clear-channel setting
ignores the table: every bit on the link, framing positions included, goes to
one configured channel.

Top module: `tsd_demux`

## Requirements
- R1: After reset `out_valid` and `out_first` are low, every timeslot is unassigned and every channel is in 64 kbit/s format. With no map writes, a channelised frame yields no valid bits.
- R2: A bit accepted with `link_valid` and `frame_sync` high is bit 0 of a frame. With `cfg_e1`=0 the frame is 193 bits: one framing bit, then timeslots 0..23 of 8 bits each. With `cfg_e1`=1 the frame is timeslots 0..31 of 8 bits each. Within a timeslot the bit index runs 0..7 in line order. After the last bit the position wraps to bit 0 of a frame.
- R3: One clock after a bit is accepted in a payload position of an assigned timeslot, `out_valid` is high, `out_bit` equals that bit, and `out_chan` is the channel written for that timeslot.
- R4: In channelised mode the T1 framing bit never produces `out_valid`.
- R5: In channelised E1 mode timeslot 0 never produces `out_valid`, even if the map marks it as assigned.
- R6: A timeslot whose map entry has `map_assign`=0 produces no `out_valid`.
- R7: Map entries are independent, so any number of timeslots may be assigned to one channel: all 24 T1 timeslots or all 31 E1 payload timeslots.
- R8: When a channel's format bit is 1 (56 kbit/s), bit index 7 of each of its timeslots gives no `out_valid`. Bit indices 0..6 are delivered.
- R9: With `cfg_clear`=1 every accepted bit, framing bit and E1 timeslot 0 included, is delivered on channel `cfg_clear_chan`. The map and the 56 kbit/s settings have no effect in this mode.
- R10: `out_first` is high together with `out_valid` exactly when the delivered bit is bit index 0 of a timeslot.
- R11: A cycle with `link_valid` low gives `out_valid` low one clock later and does not advance the frame position.
- R12: A map or format write takes effect for bits accepted in later cycles. Rewriting a timeslot as unassigned stops its delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_bit | input | 1 | Serial line bit |
| link_valid | input | 1 | Qualifies link_bit this cycle |
| frame_sync | input | 1 | With link_valid, marks bit 0 of a frame |
| cfg_e1 | input | 1 | 1 = E1 frame, 0 = T1/J1 frame |
| cfg_clear | input | 1 | 1 = clear-channel mode |
| cfg_clear_chan | input | CH_W | Channel used in clear-channel mode |
| map_we | input | 1 | Timeslot map write strobe |
| map_slot | input | 5 | Timeslot being written |
| map_assign | input | 1 | 1 = timeslot belongs to map_chan |
| map_chan | input | CH_W | Channel for the timeslot |
| fmt_we | input | 1 | Channel format write strobe |
| fmt_chan | input | CH_W | Channel being written |
| fmt_56k | input | 1 | 1 = 56 kbit/s, 0 = 64 kbit/s |
| out_valid | output | 1 | A channel bit is presented |
| out_bit | output | 1 | Delivered bit |
| out_chan | output | CH_W | Owning channel |
| out_first | output | 1 | Bit is the first of a timeslot octet |

## Verification
The bench walks whole T1 and E1 frames and checks every bit position. It targets the framing bit and E1 timeslot 0: a design that counted either as payload would leak a framing bit into a channel or shift every later timeslot by one position. Channels in 56 kbit/s format catch a design that drops the wrong bit index or drops bits on every channel. Idle gaps and a resync in mid-frame catch a position counter that advances without a bit or ignores the sync pulse. The clear-channel runs program a full map and 56 kbit/s formats, so a design that let either leak into that mode would show missing bits or the wrong channel.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    localparam int SLOT_W     = 5;
    localparam int NUM_SLOTS  = 32;
    localparam int T1_SLOTS   = 24;
    localparam int E1_SLOTS   = 32;
    localparam int BITS_W     = 3;

    typedef struct packed {
        logic              fbit;   // T1 framing position
        logic [SLOT_W-1:0] slot;
        logic [BITS_W-1:0] bitn;   // 0 = first bit on the line
    } pos_t;

    function automatic logic [SLOT_W-1:0] last_slot(logic e1);
        return e1 ? SLOT_W'(E1_SLOTS - 1) : SLOT_W'(T1_SLOTS - 1);
    endfunction

    function automatic pos_t pos_start(logic e1);
        pos_t p;
        p.fbit = !e1;
        p.slot = '0;
        p.bitn = '0;
        return p;
    endfunction

    function automatic pos_t pos_step(pos_t p, logic e1);
        pos_t n;
        n = p;
        if (p.fbit) begin
            n.fbit = 1'b0;
            n.slot = '0;
            n.bitn = '0;
        end else if (p.bitn != '1) begin
            n.bitn = p.bitn + 1'b1;
        end else if (p.slot == last_slot(e1)) begin
            n = pos_start(e1);
        end else begin
            n.bitn = '0;
            n.slot = p.slot + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/tsd_pos_counter.sv
module tsd_pos_counter
    import tsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic sync,
    input  logic e1,
    output pos_t cur
);
    pos_t nxt_q;

    // A sync pulse forces the current bit to frame position 0
    assign cur = sync ? pos_start(e1) : nxt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_q <= pos_start(e1);
        end else if (adv) begin
            nxt_q <= pos_step(cur, e1);
        end
    end
endmodule

// File: rtl/tsd_map_table.sv
module tsd_map_table
    import tsd_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    localparam int CH_W    = $clog2(NUM_CHAN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_we,
    input  logic [SLOT_W-1:0] map_slot,
    input  logic              map_assign,
    input  logic [CH_W-1:0]   map_chan,
    input  logic              fmt_we,
    input  logic [CH_W-1:0]   fmt_chan,
    input  logic              fmt_56k,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_assign,
    output logic [CH_W-1:0]   rd_chan,
    output logic              rd_56k
);
    logic [CH_W:0]       ent_q [NUM_SLOTS];
    logic [NUM_CHAN-1:0] fmt_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[s] <= '0;
            end else if (map_we && map_slot == SLOT_W'(s)) begin
                ent_q[s] <= {map_assign, map_chan};
            end
        end
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                fmt_q[c] <= 1'b0;
            end else if (fmt_we && fmt_chan == CH_W'(c)) begin
                fmt_q[c] <= fmt_56k;
            end
        end
    end

    assign rd_assign = ent_q[rd_slot][CH_W];
    assign rd_chan   = ent_q[rd_slot][CH_W-1:0];
    assign rd_56k    = fmt_q[rd_chan];
endmodule

// File: rtl/tsd_demux.sv
module tsd_demux
    import tsd_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    localparam int CH_W    = $clog2(NUM_CHAN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_bit,
    input  logic              link_valid,
    input  logic              frame_sync,
    input  logic              cfg_e1,
    input  logic              cfg_clear,
    input  logic [CH_W-1:0]   cfg_clear_chan,
    input  logic              map_we,
    input  logic [SLOT_W-1:0] map_slot,
    input  logic              map_assign,
    input  logic [CH_W-1:0]   map_chan,
    input  logic              fmt_we,
    input  logic [CH_W-1:0]   fmt_chan,
    input  logic              fmt_56k,
    output logic              out_valid,
    output logic              out_bit,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_first
);
    pos_t            pos;
    logic            ent_assign;
    logic [CH_W-1:0] ent_chan;
    logic            ent_56k;
    logic            take;
    logic            first;
    logic [CH_W-1:0] chan_sel;

    tsd_pos_counter u_pos (
        .clk  (clk),
        .rst  (rst),
        .adv  (link_valid),
        .sync (link_valid && frame_sync),
        .e1   (cfg_e1),
        .cur  (pos)
    );

    tsd_map_table #(.NUM_CHAN(NUM_CHAN)) u_map (
        .clk        (clk),
        .rst        (rst),
        .map_we     (map_we),
        .map_slot   (map_slot),
        .map_assign (map_assign),
        .map_chan   (map_chan),
        .fmt_we     (fmt_we),
        .fmt_chan   (fmt_chan),
        .fmt_56k    (fmt_56k),
        .rd_slot    (pos.slot),
        .rd_assign  (ent_assign),
        .rd_chan    (ent_chan),
        .rd_56k     (ent_56k)
    );

    always_comb begin
        first = !pos.fbit && pos.bitn == '0;
        if (cfg_clear) begin
            take     = 1'b1;
            chan_sel = cfg_clear_chan;
        end else begin
            take = !pos.fbit
                && !(cfg_e1 && pos.slot == '0)
                && ent_assign
                && !(ent_56k && pos.bitn == '1);
            chan_sel = ent_chan;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_chan  <= '0;
            out_first <= 1'b0;
        end else begin
            out_valid <= link_valid && take;
            out_first <= link_valid && take && first;
            if (link_valid && take) begin
                out_bit  <= link_bit;
                out_chan <= chan_sel;
            end
        end
    end
endmodule

// File: rtl/tsd_demux_chk.sv
module tsd_demux_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            link_bit,
    input logic            link_valid,
    input logic            frame_sync,
    input logic            cfg_clear,
    input logic [CH_W-1:0] cfg_clear_chan,
    input logic            out_valid,
    input logic            out_bit,
    input logic [CH_W-1:0] out_chan,
    input logic            out_first
);
    // R11: no accepted bit, no delivered bit
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !link_valid |=> !out_valid);

    // R4 / R5: frame bit 0 is framing in both channelised formats
    a_r4_frame_start_dropped: assert property (@(posedge clk) disable iff (rst)
        (link_valid && frame_sync && !cfg_clear) |=> !out_valid);

    // R9: clear-channel mode delivers everything to the configured channel
    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        (link_valid && cfg_clear) |=> (out_valid && out_chan == $past(cfg_clear_chan)));

    // R3: a delivered bit is the bit that was accepted
    a_r3_bit_passes: assert property (@(posedge clk) disable iff (rst)
        link_valid |=> (!out_valid || out_bit == $past(link_bit)));

    // R10: the octet marker only accompanies a delivered bit
    a_r10_first_valid: assert property (@(posedge clk) disable iff (rst)
        out_first |-> out_valid);
endmodule

bind tsd_demux tsd_demux_chk #(.CH_W(CH_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .link_bit       (link_bit),
    .link_valid     (link_valid),
    .frame_sync     (frame_sync),
    .cfg_clear      (cfg_clear),
    .cfg_clear_chan (cfg_clear_chan),
    .out_valid      (out_valid),
    .out_bit        (out_bit),
    .out_chan       (out_chan),
    .out_first      (out_first)
);

// File: tb/tsd_demux_bench.sv
module tsd_demux_bench;
    localparam int NCH  = 8;
    localparam int CW   = $clog2(NCH);
    localparam int CLR_CH = 5;

    // Scenario vectors: {e1, clear, fmt56_on, map_style}
    // map_style 0: slot s -> chan s%8, unassigned when s%4==3; style 1: all -> chan 2
    localparam logic [3:0] SCN [8] = '{
        4'b0000, 4'b0010, 4'b1010, 4'b1001,
        4'b0001, 4'b0011, 4'b0110, 4'b1110
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_bit = 1'b0, link_valid = 1'b0, frame_sync = 1'b0;
    logic cfg_e1 = 1'b0, cfg_clear = 1'b0;
    logic [CW-1:0] cfg_clear_chan = CW'(CLR_CH);
    logic map_we = 1'b0, map_assign = 1'b0;
    logic [4:0] map_slot = '0;
    logic [CW-1:0] map_chan = '0;
    logic fmt_we = 1'b0, fmt_56k = 1'b0;
    logic [CW-1:0] fmt_chan = '0;
    logic out_valid, out_bit, out_first;
    logic [CW-1:0] out_chan;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench copy of what has been written to the map
    logic          bm_asg [32];
    logic [CW-1:0] bm_chan [32];
    logic          bm_56 [NCH];

    always #2.5 clk = ~clk;

    tsd_demux #(.NUM_CHAN(NCH)) u_tsd_demux (
        .clk(clk), .rst(rst), .link_bit(link_bit), .link_valid(link_valid),
        .frame_sync(frame_sync), .cfg_e1(cfg_e1), .cfg_clear(cfg_clear),
        .cfg_clear_chan(cfg_clear_chan), .map_we(map_we), .map_slot(map_slot),
        .map_assign(map_assign), .map_chan(map_chan), .fmt_we(fmt_we),
        .fmt_chan(fmt_chan), .fmt_56k(fmt_56k), .out_valid(out_valid),
        .out_bit(out_bit), .out_chan(out_chan), .out_first(out_first)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_map(int s, bit a, int c);
        map_we = 1'b1; map_slot = 5'(s); map_assign = a; map_chan = CW'(c);
        @(negedge clk);
        map_we = 1'b0;
        bm_asg[s] = a; bm_chan[s] = CW'(c);
    endtask

    task automatic wr_fmt(int c, bit f);
        fmt_we = 1'b1; fmt_chan = CW'(c); fmt_56k = f;
        @(negedge clk);
        fmt_we = 1'b0;
        bm_56[c] = f;
    endtask

    task automatic idle_cycle();
        link_valid = 1'b0; frame_sync = 1'b0;
        @(negedge clk);
        chk("R11 idle", int'(out_valid), 0);
    endtask

    // Send frame bit k and check the delivered result one clock later
    task automatic send_bit(int k, bit sync);
        bit fb; int slot; int bn; bit ev; bit ef; int ech; string why; bit b;
        fb   = !cfg_e1 && k == 0;
        slot = cfg_e1 ? k / 8 : (k - 1) / 8;
        bn   = cfg_e1 ? k % 8 : (k - 1) % 8;
        b    = 1'(((k * 5) + (k / 7)) % 3 == 0);
        if (cfg_clear) begin
            ev = 1'b1; ech = CLR_CH; why = "R9 clear";
        end else if (fb) begin
            ev = 1'b0; ech = 0; why = "R4 T1 framing";
        end else if (cfg_e1 && slot == 0) begin
            ev = 1'b0; ech = 0; why = "R5 E1 slot0";
        end else if (!bm_asg[slot]) begin
            ev = 1'b0; ech = 0; why = "R6 unassigned";
        end else if (bm_56[bm_chan[slot]] && bn == 7) begin
            ev = 1'b0; ech = 0; why = "R8 56k drop";
        end else begin
            ev = 1'b1; ech = int'(bm_chan[slot]); why = "R2 R3 payload";
        end
        ef = ev && !fb && bn == 0;
        link_valid = 1'b1; frame_sync = sync; link_bit = b;
        @(negedge clk);
        link_valid = 1'b0; frame_sync = 1'b0;
        chk(why, int'(out_valid), int'(ev));
        chk("R10 first", int'(out_first), int'(ef));
        if (ev) begin
            chk({why, " chan"}, int'(out_chan), ech);
            chk({why, " bit"}, int'(out_bit), int'(b));
        end
    endtask

    task automatic run_frame(int nbits, bit gaps);
        for (int k = 0; k < nbits; k++) begin
            if (gaps && k % 13 == 5) idle_cycle();
            send_bit(k, k == 0);
        end
    endtask

    function automatic int flen();
        return cfg_e1 ? 256 : 193;
    endfunction

    initial begin
        for (int s = 0; s < 32; s++) begin bm_asg[s] = 1'b0; bm_chan[s] = '0; end
        for (int c = 0; c < NCH; c++) bm_56[c] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset first", int'(out_first), 0);
        // R1: empty map delivers nothing in a whole T1 frame
        run_frame(193, 1'b0);

        // Scenario table
        for (int i = 0; i < 8; i++) begin
            cfg_e1 = SCN[i][3];
            cfg_clear = SCN[i][2];
            for (int s = 0; s < 32; s++) begin
                if (SCN[i][0]) wr_map(s, 1'b1, 2);              // R7 all slots to one channel
                else wr_map(s, s % 4 != 3, s % NCH);
            end
            for (int c = 0; c < NCH; c++)
                wr_fmt(c, SCN[i][1] && c == (SCN[i][0] ? 2 : 1));
            run_frame(flen(), 1'b1);
            run_frame(flen(), 1'b0);
        end

        // R2: resync in mid-frame realigns the position
        cfg_e1 = 1'b0; cfg_clear = 1'b0;
        for (int s = 0; s < 32; s++) wr_map(s, s % 4 != 3, s % NCH);
        for (int c = 0; c < NCH; c++) wr_fmt(c, 1'b0);
        run_frame(77, 1'b0);
        run_frame(193, 1'b0);

        // R12: rewriting a slot as unassigned stops delivery; format change applies
        wr_map(4, 1'b0, 4);
        wr_fmt(5, 1'b1);
        run_frame(193, 1'b0);
        chk("R12 slot4 cleared", int'(bm_asg[4]), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule